// File: doc/BRIEF.md
# Self-Write Program Flash Controller

This block lets a processor program its own code store one word at a time through a small register window. The host places a word address and a data word in two byte-wide register pairs. It can then either launch a read, which copies the addressed word into the data pair, or launch a write. A write is only accepted right after a two-step unlock key.

Writes are staged four words at a time. Words for the first three slots of an aligned block only fill a staging buffer. The word for the last slot triggers the real operation: the whole 16-word row that holds the block is erased to all ones, and then the four staged words are programmed.

The flash array is a behavioural memory, and erase and program time are stood in for by cycle counters. Rows below a protection limit are never altered.

Top module: `pflash_selfwrite`

## Requirements
- R1: The register map is: index 0 is address low byte, 1 is address high bits, 2 is data low byte, 3 is data high bits, 4 is control, 5 is key. A control write with bit 0 set while idle launches a read. The data pair shows the addressed word after the following clock edge, not at the edge of the control write. It then keeps that word until the next read completes or the host writes index 2 or 3.
- R2: A write is accepted only when the last three register writes were: 55h to the key register, then AAh to the key register, then a control write with bit 1 set. Any other register write after either key byte cancels the attempt. A cancelled attempt starts nothing and leaves the array unchanged.
- R3: An accepted write whose address has low bits 00, 01 or 10 only stores the data word in the staging slot picked by those bits. The array is unchanged.
- R4: An accepted write whose address has low bits 11 first sets all 16 words of the enclosing row (address bits 3:0 spanning 0 to 15) to 3FFFh. It then writes the four staging slots to the four words of the block. Busy lasts 3 + ERASE_CYC + PROG_CYC cycles.
- R5: A staging slot not loaded since the last block commit programs 3FFFh. All slots return to 3FFFh after every offset-11 write.
- R6: A write whose row lies below word address PROT_WORDS leaves the array unchanged. Its offset-11 write ends after the setup and load cycles, without erase or program time.
- R7: Control bit 7 (busy) and bit 1 (write in progress) stay high from acceptance until the operation ends, and then clear by themselves. Control writes made while busy start neither a read nor a write.
- R8: Two setup cycles follow acceptance before the staging slot is loaded. A write with offset 00, 01 or 10 keeps busy high for exactly 3 cycles.
- R9: After reset the control, address and data registers read zero and every array word reads 3FFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| busy | output | 1 | High while a write operation is in progress |

## Verification
A wrong unlock state shows either as a write that starts when it should not or as one that never starts. Either way it is visible on the busy bit at the first cycle after the control write. Faults in the staging slots or in the row erase stay hidden until the offset-11 commit. After that commit, reading every word of the row back exposes a stale slot, a word that was not erased, or a word written to the wrong place, within one row scan. A miscounted setup, erase or program phase shows at once in the number of cycles busy stays high. A faulty hold on the data pair shows as a changed value in the idle cycles after a read.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam logic [2:0] RA_ADR_L = 3'd0;
  localparam logic [2:0] RA_ADR_H = 3'd1;
  localparam logic [2:0] RA_DAT_L = 3'd2;
  localparam logic [2:0] RA_DAT_H = 3'd3;
  localparam logic [2:0] RA_CTRL  = 3'd4;
  localparam logic [2:0] RA_KEY   = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_BUSY = 7;

  localparam int BLK_WORDS = 4;
  localparam int ROW_WORDS = 16;
  localparam int SETUP_CYC = 2;

  typedef enum logic [1:0] {UK_IDLE, UK_FIRST, UK_ARMED} unlock_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_SETUP, SQ_LOAD, SQ_ERASE, SQ_PROG} seq_e;

  // a row base below the limit is guarded against change
  function automatic logic in_guard(input logic [31:0] word_addr, input int unsigned limit);
    return word_addr < limit;
  endfunction
endpackage

// File: rtl/spf_unlock.sv
module spf_unlock
  import spf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       busy,
  output logic       start
);
  unlock_e st_q, st_d;
  logic    key_wr;
  logic    ctrl_wr_bit;

  assign key_wr      = reg_we && (reg_addr == RA_KEY);
  assign ctrl_wr_bit = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_WR];

  always_comb begin
    st_d = st_q;
    if (reg_we) begin
      case (st_q)
        UK_IDLE:  st_d = (key_wr && reg_wdata == KEY_FIRST)  ? UK_FIRST : UK_IDLE;
        UK_FIRST: st_d = (key_wr && reg_wdata == KEY_SECOND) ? UK_ARMED : UK_IDLE;
        default:  st_d = UK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UK_IDLE;
    else        st_q <= st_d;
  end

  assign start = (st_q == UK_ARMED) && ctrl_wr_bit && !busy;

  AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && st_q == UK_ARMED) |=> (st_q == UK_IDLE)) else $error("armed state survived a register write"); // R2
  AST_START_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n) start |-> $past(st_q != UK_IDLE)) else $error("start without key progress"); // R2
endmodule

// File: rtl/spf_seq.sv
module spf_seq
  import spf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 14,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 10,
  parameter int PROT_WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_data,
  output logic                        busy,
  output logic                        ld_pulse,
  output logic                        erase_pulse,
  output logic                        prog_pulse,
  output logic [ADDR_W-5:0]           row_idx,
  output logic [ADDR_W-3:0]           blk_idx,
  output logic [BLK_WORDS*DATA_W-1:0] buf_flat
);
  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_e              st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic [DATA_W-1:0] buf_q [BLK_WORDS];
  logic [1:0]        op_off;
  logic              op_prot;

  assign op_off  = op_addr_q[1:0];
  assign op_prot = in_guard(32'({op_addr_q[ADDR_W-1:4], 4'b0000}), PROT_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
      for (int i = 0; i < BLK_WORDS; i++) buf_q[i] <= '1;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          st_q      <= SQ_SETUP;
          cnt_q     <= '0;
          op_addr_q <= req_addr;
          op_data_q <= req_data;
        end
        SQ_SETUP: begin
          if (cnt_q == CNT_W'(SETUP_CYC - 1)) st_q <= SQ_LOAD;
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        SQ_LOAD: begin
          buf_q[op_off] <= op_data_q;
          cnt_q         <= '0;
          if (op_off != 2'b11) st_q <= SQ_IDLE;
          else if (op_prot) begin
            st_q <= SQ_IDLE;
            for (int i = 0; i < BLK_WORDS; i++) buf_q[i] <= '1;
          end else st_q <= SQ_ERASE;
        end
        SQ_ERASE: begin
          if (cnt_q == CNT_W'(ERASE_CYC - 1)) begin
            st_q  <= SQ_PROG;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        SQ_PROG: begin
          if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
            st_q <= SQ_IDLE;
            for (int i = 0; i < BLK_WORDS; i++) buf_q[i] <= '1;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != SQ_IDLE);
  assign ld_pulse    = (st_q == SQ_LOAD);
  assign erase_pulse = (st_q == SQ_ERASE) && (cnt_q == CNT_W'(ERASE_CYC - 1));
  assign prog_pulse  = (st_q == SQ_PROG) && (cnt_q == CNT_W'(PROG_CYC - 1));
  assign row_idx     = op_addr_q[ADDR_W-1:4];
  assign blk_idx     = op_addr_q[ADDR_W-1:2];

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_buf
    assign buf_flat[g*DATA_W +: DATA_W] = buf_q[g];
  end

  AST_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n) ld_pulse |-> ($past(busy) && $past(busy, 2))) else $error("load without two setup cycles"); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ($past(ld_pulse) || $past(prog_pulse))) else $error("busy dropped mid operation"); // R7
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ld_pulse, erase_pulse, prog_pulse})) else $error("overlapping steps"); // R4
endmodule

// File: rtl/spf_array.sv
module spf_array
  import spf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 14,
  parameter int PROT_WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        erase_en,
  input  logic [ADDR_W-5:0]           erase_row,
  input  logic                        prog_en,
  input  logic [ADDR_W-3:0]           prog_blk,
  input  logic [BLK_WORDS*DATA_W-1:0] prog_words,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_en) begin
      for (int i = 0; i < ROW_WORDS; i++) mem_q[{erase_row, 4'(i)}] <= '1;
    end else if (prog_en) begin
      for (int j = 0; j < BLK_WORDS; j++) mem_q[{prog_blk, 2'(j)}] <= prog_words[j*DATA_W +: DATA_W];
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_GUARD_ERASE: assert property (@(posedge clk) disable iff (!rst_n) erase_en |-> !in_guard(32'({erase_row, 4'b0000}), PROT_WORDS)) else $error("erase in guarded row"); // R6
  AST_GUARD_PROG: assert property (@(posedge clk) disable iff (!rst_n) prog_en |-> !in_guard(32'({prog_blk[ADDR_W-3:2], 4'b0000}), PROT_WORDS)) else $error("program in guarded row"); // R6
endmodule

// File: rtl/pflash_selfwrite.sv
module pflash_selfwrite
  import spf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 14,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 10,
  parameter int PROT_WORDS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy
);
  localparam int AH_W = ADDR_W - 8;
  localparam int DH_W = DATA_W - 8;

  logic [ADDR_W-1:0]           adr_q;
  logic [DATA_W-1:0]           dat_q;
  logic                        rd_pend_q;
  logic                        start;
  logic                        rd_req;
  logic                        host_dat_wr;
  logic [DATA_W-1:0]           rd_word;
  logic                        ld_pulse, erase_pulse, prog_pulse;
  logic [ADDR_W-5:0]           row_idx;
  logic [ADDR_W-3:0]           blk_idx;
  logic [BLK_WORDS*DATA_W-1:0] buf_flat;

  assign rd_req      = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_RD] && !busy && !start;
  assign host_dat_wr = reg_we && ((reg_addr == RA_DAT_L) || (reg_addr == RA_DAT_H));

  spf_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .start(start)
  );

  spf_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC),
    .PROG_CYC(PROG_CYC), .PROT_WORDS(PROT_WORDS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(adr_q), .req_data(dat_q),
    .busy(busy), .ld_pulse(ld_pulse), .erase_pulse(erase_pulse), .prog_pulse(prog_pulse),
    .row_idx(row_idx), .blk_idx(blk_idx), .buf_flat(buf_flat)
  );

  spf_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_WORDS(PROT_WORDS)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .erase_en(erase_pulse), .erase_row(row_idx),
    .prog_en(prog_pulse), .prog_blk(blk_idx), .prog_words(buf_flat),
    .rd_addr(adr_q), .rd_data(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q     <= '0;
      dat_q     <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_req;
      if (rd_pend_q) dat_q <= rd_word;
      if (reg_we) begin
        case (reg_addr)
          RA_ADR_L: adr_q[7:0]        <= reg_wdata;
          RA_ADR_H: adr_q[ADDR_W-1:8] <= reg_wdata[AH_W-1:0];
          RA_DAT_L: dat_q[7:0]        <= reg_wdata;
          RA_DAT_H: dat_q[DATA_W-1:8] <= reg_wdata[DH_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_ADR_L: reg_rdata = adr_q[7:0];
      RA_ADR_H: reg_rdata = 8'(adr_q[ADDR_W-1:8]);
      RA_DAT_L: reg_rdata = dat_q[7:0];
      RA_DAT_H: reg_rdata = 8'(dat_q[DATA_W-1:8]);
      RA_CTRL:  reg_rdata = {busy, 5'b00000, busy, rd_pend_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$past(rd_pend_q) && !$past(host_dat_wr)) |-> $stable(dat_q)) else $error("data pair changed without cause"); // R1
  AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (rd_pend_q && !host_dat_wr) |=> (dat_q == $past(rd_word))) else $error("read result not captured"); // R1
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !rd_pend_q) else $error("read launched while busy"); // R7
endmodule

// File: tb/pflash_selfwrite_test.sv
module pflash_selfwrite_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 14;
  localparam int ERASE_CYC  = 20;
  localparam int PROG_CYC   = 10;
  localparam int PROT_WORDS = 16;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       busy;

  int n_chk = 0;
  int n_err = 0;

  logic [DATA_W-1:0] model_mem [2**ADDR_W];
  logic [DATA_W-1:0] model_buf [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_selfwrite #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC),
    .PROG_CYC(PROG_CYC), .PROT_WORDS(PROT_WORDS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit guarded(input logic [ADDR_W-1:0] a);
    return ({a[ADDR_W-1:4], 4'b0000} < PROT_WORDS);
  endfunction

  function automatic int exp_busy(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b11 && !guarded(a)) ? 3 + ERASE_CYC + PROG_CYC : 3;
  endfunction

  task automatic model_apply(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] w);
    model_buf[a[1:0]] = w;
    if (a[1:0] == 2'b11) begin
      if (!guarded(a)) begin
        for (int i = 0; i < 16; i++) model_mem[{a[ADDR_W-1:4], 4'(i)}] = ONES;
        for (int j = 0; j < 4; j++) model_mem[{a[ADDR_W-1:2], 2'(j)}] = model_buf[j];
      end
      for (int j = 0; j < 4; j++) model_buf[j] = ONES;
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_addr(input logic [ADDR_W-1:0] a);
    reg_wr(3'd0, a[7:0]);
    reg_wr(3'd1, 8'(a[ADDR_W-1:8]));
  endtask

  task automatic set_data(input logic [DATA_W-1:0] w);
    reg_wr(3'd2, w[7:0]);
    reg_wr(3'd3, 8'(w[DATA_W-1:8]));
  endtask

  task automatic read_word(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] w);
    logic [7:0] lo, hi;
    set_addr(a);
    reg_wr(3'd4, 8'h01);
    @(negedge clk);
    reg_rd(3'd2, lo);
    reg_rd(3'd3, hi);
    w = {hi[DATA_W-9:0], lo};
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] c;
    cyc = 0;
    reg_rd(3'd4, c);
    while (c[7] && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      reg_rd(3'd4, c);
    end
  endtask

  task automatic flash_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] w, input string tag);
    int cyc;
    set_addr(a);
    set_data(w);
    reg_wr(3'd5, 8'h55);
    reg_wr(3'd5, 8'hAA);
    reg_wr(3'd4, 8'h02);
    wait_idle(cyc);
    check(cyc == exp_busy(a), tag, cyc, exp_busy(a));
    model_apply(a, w);
  endtask

  task automatic verify_row(input logic [ADDR_W-5:0] r, input string tag);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < 16; i++) begin
      read_word({r, 4'(i)}, w);
      check(w == model_mem[{r, 4'(i)}], tag, w, model_mem[{r, 4'(i)}]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]        b;
    logic [DATA_W-1:0] w;
    int                cyc;
    void'($urandom(32'd1357));
    for (int i = 0; i < 2**ADDR_W; i++) model_mem[i] = ONES;
    for (int j = 0; j < 4; j++) model_buf[j] = ONES;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    reg_rd(3'd4, b); check(b == 8'h00, "R9 ctrl", b, 0);
    reg_rd(3'd0, b); check(b == 8'h00, "R9 adr", b, 0);
    reg_rd(3'd2, b); check(b == 8'h00, "R9 dat", b, 0);
    read_word(10'h155, w); check(w == ONES, "R9 array erased", w, ONES);

    // R4 erase of the row before programming: seed a word, then commit another block of the row
    flash_write(10'h027, 14'h0555, "R4 busy length");
    read_word(10'h027, w); check(w == 14'h0555, "R4 single slot", w, 14'h0555);
    flash_write(10'h021, 14'h1234, "R8 busy length");
    read_word(10'h021, w); check(w == ONES, "R3 buffer only", w, ONES);
    flash_write(10'h023, 14'h0ABC, "R4 busy length");
    verify_row(6'h02, "R4 row after commit");
    check(model_mem[10'h027] == ONES, "R4 model erase", model_mem[10'h027], ONES);
    read_word(10'h020, w); check(w == ONES, "R5 unloaded slot", w, ONES);

    // R5 staging slots reset after commit
    flash_write(10'h033, 14'h0042, "R4 busy length");
    read_word(10'h031, w); check(w == ONES, "R5 slots cleared", w, ONES);

    // R2 wrong key byte cancels
    set_addr(10'h043);
    set_data(14'h0111);
    reg_wr(3'd5, 8'h55);
    reg_wr(3'd5, 8'h12);
    reg_wr(3'd5, 8'hAA);
    reg_wr(3'd4, 8'h02);
    reg_rd(3'd4, b); check(b == 8'h00, "R2 bad key", b, 0);
    // R2 intervening register write cancels
    reg_wr(3'd5, 8'h55);
    reg_wr(3'd5, 8'hAA);
    reg_wr(3'd0, 8'h43);
    reg_wr(3'd4, 8'h02);
    reg_rd(3'd4, b); check(b == 8'h00, "R2 interleaved write", b, 0);
    read_word(10'h043, w); check(w == ONES, "R2 array unchanged", w, ONES);

    // R7 control writes while busy are ignored
    set_addr(10'h057);
    set_data(14'h0222);
    reg_wr(3'd5, 8'h55);
    reg_wr(3'd5, 8'hAA);
    reg_wr(3'd4, 8'h02);
    reg_rd(3'd4, b); check(b == 8'h82, "R7 busy and write bits", b, 8'h82);
    reg_wr(3'd4, 8'h01);
    reg_rd(3'd4, b); check(b[0] == 1'b0, "R7 read ignored", b[0], 0);
    @(negedge clk);
    reg_rd(3'd2, b); check(b == 8'h22, "R7 data pair kept", b, 8'h22);
    wait_idle(cyc);
    reg_rd(3'd4, b); check(b == 8'h00, "R7 bits self clear", b, 0);
    model_apply(10'h057, 14'h0222);
    read_word(10'h057, w); check(w == 14'h0222, "R7 write completed", w, 14'h0222);

    // R1 read latency and hold
    read_word(10'h023, w); check(w == 14'h0ABC, "R1 read value", w, 14'h0ABC);
    set_addr(10'h027);
    repeat (3) @(negedge clk);
    reg_rd(3'd2, b); check(b == 8'hBC, "R1 hold", b, 8'hBC);
    reg_wr(3'd2, 8'h5A);
    reg_rd(3'd2, b); check(b == 8'h5A, "R1 host write", b, 8'h5A);
    set_addr(10'h023);
    reg_wr(3'd4, 8'h01);
    reg_rd(3'd2, b); check(b == 8'h5A, "R1 not yet loaded", b, 8'h5A);
    @(negedge clk);
    reg_rd(3'd2, b); check(b == 8'hBC, "R1 loaded next cycle", b, 8'hBC);

    // R6 guarded row
    flash_write(10'h001, 14'h0777, "R8 busy length");
    flash_write(10'h003, 14'h0001, "R6 guarded length");
    verify_row(6'h00, "R6 guarded row");

    // random blocks with partial loads
    for (int it = 0; it < 20; it++) begin
      logic [ADDR_W-5:0] r;
      logic [1:0]        blk;
      logic [2:0]        mask;
      r    = 6'(1 + ($urandom % 63));
      blk  = 2'($urandom);
      mask = 3'($urandom);
      for (int o = 0; o < 3; o++)
        if (mask[o]) flash_write({r, blk, 2'(o)}, 14'($urandom), "R8 busy length");
      flash_write({r, blk, 2'b11}, 14'($urandom), "R4 busy length");
      verify_row(r, "R5 random row");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule